// File: doc/BRIEF.md
# Integer ALU with Selective Overflow

This block is the purely combinational integer datapath of a load/store RISC core. Each cycle the core presents two register operands, a 16-bit immediate field, a 5-bit constant shift amount and a 5-bit operation code. The block returns a 32-bit result and an overflow flag in the same cycle, with no state of its own.

The overflow flag is raised only by the three signed arithmetic operations. The core uses it to start an exception. The unsigned arithmetic forms wrap silently.

The immediate is extended in one of two ways. Arithmetic forms copy its top bit into the upper half, and logical forms fill the upper half with zeros.

Shifts always move operand B. The amount comes either from the constant field or from the low five bits of operand A.

Top module: `alu32`

## Requirements
- R1: Codes 0 (add), 2 (subtract, A minus B) and 4 (add-immediate) produce the wrapped 32-bit result. They assert `ovf_o` exactly when the true two's-complement result lies outside the signed 32-bit range.
- R2: Codes 1 (unsigned add), 3 (unsigned subtract) and 5 (unsigned add-immediate) produce the wrapped 32-bit result and never assert `ovf_o`. No code other than 0, 2 and 4 ever asserts `ovf_o`.
- R3: Codes 4 and 5 add operand A to the immediate after sign extension, with immediate bit 15 copied into bits 31:16.
- R4: Codes 6, 7, 8 and 9 return A AND B, A OR B, A XOR B and NOT (A OR B) respectively.
- R5: Codes 10, 11 and 12 return A AND, OR and XOR the immediate after zero extension, with bits 31:16 of the extended value equal to 0.
- R6: Codes 13, 14 and 15 shift B left logically, right logically and right arithmetically by `shamt_i`, and ignore operand A.
- R7: Codes 16, 17 and 18 perform the same three shifts of B. The amount is taken from A[4:0], and A[31:5] is ignored.
- R8: Code 19 returns the immediate in bits 31:16 and zeros in bits 15:0.
- R9: Codes 20 to 31 return a zero result with `ovf_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First register operand; supplies the variable shift amount |
| b_i | input | 32 | Second register operand; the value shifted by shift codes |
| imm_i | input | 16 | Immediate field |
| shamt_i | input | 5 | Constant shift amount |
| op_i | input | 5 | Operation code |
| result_o | output | 32 | Operation result |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The signed and unsigned arithmetic operations are driven with the same operand pairs at the edges of the signed range, positive and negative, so that wraparound is distinguished from a true overflow. A subtract of the most negative value separates correct inversion of the B sign from a naive rule.

Immediates with bit 15 set show sign extension against zero extension. The logic tests use operands with all four bit combinations in different nibbles, so that each operator is told apart from the others.

The variable shifts are driven with garbage above A[4:0], and the constant shifts with a nonzero A, which exposes use of the wrong amount source. The unused codes are tried with nonzero operands.

// File: rtl/alu32.sv
module alu32 #(
  parameter int XLEN = 32,
  parameter int IMMW = 16
) (
  input  logic [XLEN-1:0]         a_i,
  input  logic [XLEN-1:0]         b_i,
  input  logic [IMMW-1:0]         imm_i,
  input  logic [$clog2(XLEN)-1:0] shamt_i,
  input  logic [4:0]              op_i,
  output logic [XLEN-1:0]         result_o,
  output logic                    ovf_o
);
  localparam int SHW = $clog2(XLEN);
  localparam int PADW = XLEN - IMMW;

  localparam logic [4:0] OP_ADD  = 5'd0,  OP_ADDU = 5'd1,  OP_SUB  = 5'd2,
                         OP_SUBU = 5'd3,  OP_ADDI = 5'd4,  OP_ADDIU= 5'd5,
                         OP_AND  = 5'd6,  OP_OR   = 5'd7,  OP_XOR  = 5'd8,
                         OP_NOR  = 5'd9,  OP_ANDI = 5'd10, OP_ORI  = 5'd11,
                         OP_XORI = 5'd12, OP_SLL  = 5'd13, OP_SRL  = 5'd14,
                         OP_SRA  = 5'd15, OP_SLLV = 5'd16, OP_SRLV = 5'd17,
                         OP_SRAV = 5'd18, OP_LUI  = 5'd19;

  logic [XLEN-1:0] imm_sx, imm_zx, addend, sum;
  logic [SHW-1:0]  amt;
  logic            is_sub, is_imm, signed_op;

  assign imm_sx = {{PADW{imm_i[IMMW-1]}}, imm_i};
  assign imm_zx = {{PADW{1'b0}}, imm_i};

  assign is_sub    = (op_i == OP_SUB) || (op_i == OP_SUBU);
  assign is_imm    = (op_i == OP_ADDI) || (op_i == OP_ADDIU);
  assign signed_op = (op_i == OP_ADD) || (op_i == OP_SUB) || (op_i == OP_ADDI);

  assign addend = is_imm ? imm_sx : (is_sub ? ~b_i : b_i);
  assign sum    = a_i + addend + {{(XLEN-1){1'b0}}, is_sub};

  assign amt = (op_i == OP_SLLV || op_i == OP_SRLV || op_i == OP_SRAV)
             ? a_i[SHW-1:0] : shamt_i;

  always_comb begin
    case (op_i)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU,
      OP_ADDI, OP_ADDIU:  result_o = sum;
      OP_AND:             result_o = a_i & b_i;
      OP_OR:              result_o = a_i | b_i;
      OP_XOR:             result_o = a_i ^ b_i;
      OP_NOR:             result_o = ~(a_i | b_i);
      OP_ANDI:            result_o = a_i & imm_zx;
      OP_ORI:             result_o = a_i | imm_zx;
      OP_XORI:            result_o = a_i ^ imm_zx;
      OP_SLL, OP_SLLV:    result_o = b_i << amt;
      OP_SRL, OP_SRLV:    result_o = b_i >> amt;
      OP_SRA, OP_SRAV:    result_o = $unsigned($signed(b_i) >>> amt);
      OP_LUI:             result_o = {imm_i, {PADW{1'b0}}};
      default:            result_o = '0;
    endcase
  end

  assign ovf_o = signed_op && (a_i[XLEN-1] == addend[XLEN-1])
                           && (sum[XLEN-1] != a_i[XLEN-1]);
endmodule

module alu32_chk #(
  parameter int XLEN = 32
) (
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic [15:0]     imm_i,
  input logic [4:0]      op_i,
  input logic [XLEN-1:0] result_o,
  input logic            ovf_o
);
  always_comb begin
    if (op_i != 5'd0 && op_i != 5'd2 && op_i != 5'd4)
      a_r2_no_overflow: assert (!ovf_o);
    if (op_i == 5'd0)
      a_r1_add_ovf: assert (ovf_o == ((a_i[XLEN-1] == b_i[XLEN-1]) &&
                                      (result_o[XLEN-1] != a_i[XLEN-1])));
    if (op_i == 5'd2)
      a_r1_sub_ovf: assert (ovf_o == ((a_i[XLEN-1] != b_i[XLEN-1]) &&
                                      (result_o[XLEN-1] != a_i[XLEN-1])));
    if (op_i == 5'd10)
      a_r5_andi_upper_zero: assert (result_o[XLEN-1:16] == '0);
    if (op_i == 5'd19)
      a_r8_lui_low_zero: assert (result_o[15:0] == 16'h0 && result_o[XLEN-1:XLEN-16] == imm_i);
    if (op_i >= 5'd20)
      a_r9_unused_zero: assert (result_o == '0 && !ovf_o);
  end
endmodule

bind alu32 alu32_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/alu32_test.sv
module alu32_test;
  logic        clk = 1'b0;
  logic [31:0] a, b, res;
  logic [15:0] imm;
  logic [4:0]  shamt, op;
  logic        ovf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu32 uut (.a_i(a), .b_i(b), .imm_i(imm), .shamt_i(shamt), .op_i(op),
             .result_o(res), .ovf_o(ovf));

  task automatic apply(input logic [4:0] o, input logic [31:0] av, input logic [31:0] bv,
                       input logic [15:0] iv, input logic [4:0] sv);
    @(negedge clk);
    op = o; a = av; b = bv; imm = iv; shamt = sv;
    #5;
  endtask

  task automatic chk(input string req, input logic [31:0] er, input logic eo);
    checks++;
    if (res !== er || ovf !== eo) begin
      errors++;
      $display("FAIL %s op=%0d result=%h ovf=%b expected result=%h ovf=%b",
               req, op, res, ovf, er, eo);
    end
  endtask

  task automatic t_signed;
    apply(0, 32'h7fffffff, 32'h1, 0, 0);        chk("R1", 32'h80000000, 1);
    apply(0, 32'h80000000, 32'hffffffff, 0, 0); chk("R1", 32'h7fffffff, 1);
    apply(0, 32'h5, 32'hfffffffd, 0, 0);        chk("R1", 32'h2, 0);
    apply(2, 32'h80000000, 32'h1, 0, 0);        chk("R1", 32'h7fffffff, 1);
    apply(2, 32'h7fffffff, 32'hffffffff, 0, 0); chk("R1", 32'h80000000, 1);
    apply(2, 32'h0, 32'h80000000, 0, 0);        chk("R1", 32'h80000000, 1);
    apply(2, 32'hffffffff, 32'h80000000, 0, 0); chk("R1", 32'h7fffffff, 0);
    apply(2, 32'h3, 32'h5, 0, 0);               chk("R1", 32'hfffffffe, 0);
    apply(4, 32'h7ffffff0, 0, 16'h0010, 0);     chk("R1", 32'h80000000, 1);
  endtask

  task automatic t_unsigned;
    apply(1, 32'hffffffff, 32'h1, 0, 0);        chk("R2", 32'h0, 0);
    apply(1, 32'h7fffffff, 32'h1, 0, 0);        chk("R2", 32'h80000000, 0);
    apply(3, 32'h0, 32'h1, 0, 0);               chk("R2", 32'hffffffff, 0);
    apply(3, 32'h80000000, 32'h1, 0, 0);        chk("R2", 32'h7fffffff, 0);
    apply(5, 32'h7fffffff, 0, 16'h0001, 0);     chk("R2", 32'h80000000, 0);
  endtask

  task automatic t_sext;
    apply(4, 32'h10, 0, 16'hffff, 0);           chk("R3", 32'h0000000f, 0);
    apply(5, 32'h0, 0, 16'h8000, 0);            chk("R3", 32'hffff8000, 0);
    apply(4, 32'h1, 0, 16'h7fff, 0);            chk("R3", 32'h00008000, 0);
  endtask

  task automatic t_logic;
    apply(6, 32'hf0f000ff, 32'h0ff00f0f, 0, 0); chk("R4", 32'h00f0000f, 0);
    apply(7, 32'hf0f000ff, 32'h0ff00f0f, 0, 0); chk("R4", 32'hfff00fff, 0);
    apply(8, 32'hf0f000ff, 32'h0ff00f0f, 0, 0); chk("R4", 32'hff000ff0, 0);
    apply(9, 32'hf0f000ff, 32'h0ff00f0f, 0, 0); chk("R4", 32'h000ff000, 0);
  endtask

  task automatic t_zext;
    apply(10, 32'hffffffff, 32'h5, 16'h8001, 0); chk("R5", 32'h00008001, 0);
    apply(11, 32'h12340000, 32'h5, 16'h8001, 0); chk("R5", 32'h12348001, 0);
    apply(12, 32'hffff0000, 32'h5, 16'hffff, 0); chk("R5", 32'hffffffff, 0);
    apply(12, 32'h00000000, 32'h5, 16'h8000, 0); chk("R5", 32'h00008000, 0);
  endtask

  task automatic t_shift_const;
    apply(13, 32'h3, 32'h80000001, 0, 5'd4);  chk("R6", 32'h00000010, 0);
    apply(14, 32'h3, 32'h80000001, 0, 5'd4);  chk("R6", 32'h08000000, 0);
    apply(15, 32'h3, 32'h80000001, 0, 5'd4);  chk("R6", 32'hf8000000, 0);
    apply(15, 32'h0, 32'h80000000, 0, 5'd31); chk("R6", 32'hffffffff, 0);
    apply(15, 32'h0, 32'h40000000, 0, 5'd30); chk("R6", 32'h00000001, 0);
  endtask

  task automatic t_shift_var;
    apply(16, 32'hffffffe4, 32'h80000001, 0, 5'd9); chk("R7", 32'h00000010, 0);
    apply(17, 32'hffffffe4, 32'h80000001, 0, 5'd9); chk("R7", 32'h08000000, 0);
    apply(18, 32'hffffffe4, 32'h80000001, 0, 5'd9); chk("R7", 32'hf8000000, 0);
    apply(17, 32'h00000020, 32'h80000001, 0, 5'd9); chk("R7", 32'h80000001, 0);
  endtask

  task automatic t_lui;
    apply(19, 32'hffffffff, 32'hffffffff, 16'habcd, 5'd7); chk("R8", 32'habcd0000, 0);
  endtask

  task automatic t_unused;
    for (int c = 20; c < 32; c++) begin
      apply(5'(c), 32'h7fffffff, 32'h1, 16'hffff, 5'd3); chk("R9", 32'h0, 0);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    op = 0; a = 0; b = 0; imm = 0; shamt = 0;
    #1;
    checks++;
    if (res !== 32'h0 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle result=%h ovf=%b expected result=0 ovf=0", res, ovf);
    end
    t_signed;
    t_unsigned;
    t_sext;
    t_logic;
    t_zext;
    t_shift_const;
    t_shift_var;
    t_lui;
    t_unused;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule